// File: doc/BRIEF.md
# Cable Diagnostic Sequencer

This block runs a complete cable test on an Ethernet PHY through register transactions on a management bus. When `start` is pulsed, it forces the PHY to 100 Mb operation and fixes the pair mapping to straight. It then enables the PHY's test mode and checks the ability result. If the ability check passes, it repeats the reflection measurement until the readings settle or an iteration limit is reached. It then moves to the crossed mapping and tests that channel the same way. Finally it returns the PHY to normal operation.

The block does not drive MDIO pins itself. It issues one register request at a time on a request/acknowledge port to an external MDIO master, and it holds each request until that request is acknowledged. The results are kept on output ports until the next run begins. For each channel they hold a status, the distance count and the two impedance flags. Channel 0 is the straight mapping and channel 1 is the crossed mapping.

Top module: `cabdiag_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `req_valid` are 0, and every channel status is 00 (not run).
- R2: A `start` pulse while idle begins a run with three writes in this order: register 0x00 ← 0x2000, register 0x1C ← 0x0000, register 0x1D ← 0xC000.
- R3: Only one request is outstanding at a time. While `req_valid` is high and `req_ack` is low, the values of `req_write`, `req_addr` and `req_wdata` do not change.
- R4: After every write of 0xC000 to register 0x1D, a read of register 0x1D is requested exactly WAIT_CYCLES clock cycles after the clock edge that takes that write's acknowledge.
- R5: If bit 14 of the ability read is 0, the channel status becomes 11 (ability failed) with distance 0 and flags 0. The block then writes 0x0040 to register 0x1C, whatever the other bits of the read are.
- R6: If bit 14 of the ability read is 1, the block repeats the cycle of writing 0xC000 to 0x1D, waiting, and reading 0x1D. In each reading, bits 8:0 are the distance, bit 9 is the high-impedance flag and bit 10 is the low-impedance flag. Bits 15:11 are ignored. The flags output of a channel is {low, high}.
- R7: A channel is stable once MATCH_NEED consecutive readings agree in distance and both flags together. Any reading that differs restarts the count at 1. A stable channel gets status 01 and the agreeing reading.
- R8: If MAX_ITER readings are taken without reaching stability, the channel gets status 10 and the last reading.
- R9: Each finished channel is followed by a write of 0x0040 to 0x1C. After that write, channel 1 starts again from the 0xC000 write to 0x1D. After channel 1, the block writes 0x1D ← 0x0000, then 0x00 ← 0x0000, then 0x1C ← 0x0080.
- R10: `done` is high for exactly one cycle, in the cycle after the last teardown write is acknowledged. `busy` is low in that cycle, no further requests follow, and the results hold.
- R11: A `start` pulse while `busy` is high has no effect on the request sequence.
- R12: Accepting `start` clears every channel status to 00 before any new result is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (taken only when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| req_valid | output | 1 | Register request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 5 | Register address |
| req_wdata | output | 16 | Write data |
| req_ack | input | 1 | Request completed this cycle |
| req_rdata | input | 16 | Read data, valid with `req_ack` on a read |
| ch_status | output | 4 | Per-channel status, channel c at [2c+1:2c]: 00 none, 01 stable, 10 timed out, 11 ability failed |
| ch_dist | output | 18 | Per-channel distance, channel c at [9c+8:9c] |
| ch_flags | output | 4 | Per-channel flags {low, high}, channel c at [2c+1:2c] |

## Verification
The hardest state to reach is the timeout path for a channel whose distance never changes but whose impedance flags alternate. Reaching it needs a full run of MAX_ITER measurement cycles in which only the flag bits differ from one reading to the next. The bench's PHY model returns a scripted list of read values, so that channel gets 100 readings with the low and high flags swapped on each one. This makes a comparison that ignores the flags visible as a premature stable result. A second script returns two identical readings and then three of another value, which exposes a match count that fails to restart.

// File: rtl/cabdiag_pkg.sv
package cabdiag_pkg;
   localparam int NUM_CH = 2;
   localparam int DIST_W = 9;
   localparam int RD_W   = DIST_W + 2;           // {lowz, highz, dist}

   localparam logic [4:0]  A_CTRL = 5'h00;
   localparam logic [4:0]  A_MAP  = 5'h1C;
   localparam logic [4:0]  A_TST  = 5'h1D;

   localparam logic [15:0] V_FORCE100 = 16'h2000;
   localparam logic [15:0] V_ZERO     = 16'h0000;
   localparam logic [15:0] V_XOVER    = 16'h0040;
   localparam logic [15:0] V_AUTO     = 16'h0080;
   localparam logic [15:0] V_TEST     = 16'hC000;

   localparam int B_ABLE = 14;

   typedef enum logic [1:0] {
      ST_NONE    = 2'b00,
      ST_STABLE  = 2'b01,
      ST_TIMEOUT = 2'b10,
      ST_NOABLE  = 2'b11
   } ch_stat_e;

   typedef enum logic [3:0] {
      S_IDLE, S_FORCE, S_MAPSTR, S_EN, S_WAIT_AB, S_RD_AB,
      S_MEAS_WR, S_WAIT_M, S_RD_M, S_EVAL, S_XOVER,
      S_TD_TST, S_TD_CTL, S_TD_MAP
   } seq_state_e;
endpackage

// File: rtl/cabdiag_wait_timer.sv
module cabdiag_wait_timer #(
   parameter int CYCLES = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("cabdiag_wait_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load) begin
         cnt <= CW'(CYCLES - 1);
         run <= 1'b1;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign expired = run && (cnt == '0);
endmodule

// File: rtl/cabdiag_stab_track.sv
module cabdiag_stab_track #(
   parameter int MATCH_NEED = 3,
   parameter int MAX_ITER   = 100,
   parameter int W          = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         sample_en,
   input  logic [W-1:0] sample,
   output logic [W-1:0] last,
   output logic         stable,
   output logic         maxed
);
   localparam int MW = $clog2(MATCH_NEED + 1);
   localparam int IW = $clog2(MAX_ITER + 1);

   if (MATCH_NEED < 2) begin : g_bad_match
      $error("cabdiag_stab_track: MATCH_NEED must be at least 2");
   end
   if (MAX_ITER < MATCH_NEED) begin : g_bad_iter
      $error("cabdiag_stab_track: MAX_ITER must not be below MATCH_NEED");
   end

   logic [MW-1:0] match_cnt;
   logic [IW-1:0] iter_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_cnt <= '0;
         iter_cnt  <= '0;
         last      <= '0;
      end else if (clear) begin
         match_cnt <= '0;
         iter_cnt  <= '0;
         last      <= '0;
      end else if (sample_en) begin
         iter_cnt <= iter_cnt + 1'b1;
         last     <= sample;
         if (iter_cnt != '0 && sample == last)
            match_cnt <= (match_cnt == MW'(MATCH_NEED)) ? match_cnt : match_cnt + 1'b1;
         else
            match_cnt <= MW'(1);
      end
   end

   assign stable = (match_cnt == MW'(MATCH_NEED));
   assign maxed  = (iter_cnt == IW'(MAX_ITER));

   // R7
   match_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_cnt <= MW'(MATCH_NEED));

   // R8
   iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iter_cnt <= IW'(MAX_ITER));

   // R7
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !clear && iter_cnt != '0 && sample != last) |=> (match_cnt == MW'(1)));
endmodule

// File: rtl/cabdiag_seq.sv
module cabdiag_seq
   import cabdiag_pkg::*;
#(
   parameter int WAIT_CYCLES = 12500,
   parameter int MATCH_NEED  = 3,
   parameter int MAX_ITER    = 100
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   output logic                     busy,
   output logic                     done,
   output logic                     req_valid,
   output logic                     req_write,
   output logic [4:0]               req_addr,
   output logic [15:0]              req_wdata,
   input  logic                     req_ack,
   input  logic [15:0]              req_rdata,
   output logic [2*NUM_CH-1:0]      ch_status,
   output logic [DIST_W*NUM_CH-1:0] ch_dist,
   output logic [2*NUM_CH-1:0]      ch_flags
);
   localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   seq_state_e     st;
   logic [CHW-1:0] ch;
   logic           done_q;

   logic           tmr_load, tmr_exp;
   logic           trk_clear, trk_sample;
   logic [RD_W-1:0] trk_last;
   logic           trk_stable, trk_maxed;

   logic           rec_en;
   ch_stat_e       rec_stat;
   logic [RD_W-1:0] rec_data;

   cabdiag_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .expired(tmr_exp)
   );

   cabdiag_stab_track #(.MATCH_NEED(MATCH_NEED), .MAX_ITER(MAX_ITER), .W(RD_W)) u_track (
      .clk(clk), .rst_n(rst_n), .clear(trk_clear), .sample_en(trk_sample),
      .sample(req_rdata[RD_W-1:0]), .last(trk_last),
      .stable(trk_stable), .maxed(trk_maxed)
   );

   // sequencer state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         ch     <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            S_IDLE:    if (start) begin st <= S_FORCE; ch <= '0; end
            S_FORCE:   if (req_ack) st <= S_MAPSTR;
            S_MAPSTR:  if (req_ack) st <= S_EN;
            S_EN:      if (req_ack) st <= S_WAIT_AB;
            S_WAIT_AB: if (tmr_exp) st <= S_RD_AB;
            S_RD_AB:   if (req_ack) st <= req_rdata[B_ABLE] ? S_MEAS_WR : S_XOVER;
            S_MEAS_WR: if (req_ack) st <= S_WAIT_M;
            S_WAIT_M:  if (tmr_exp) st <= S_RD_M;
            S_RD_M:    if (req_ack) st <= S_EVAL;
            S_EVAL:    st <= (trk_stable || trk_maxed) ? S_XOVER : S_MEAS_WR;
            S_XOVER:   if (req_ack) begin
                          if (ch == CHW'(NUM_CH - 1)) st <= S_TD_TST;
                          else begin ch <= ch + 1'b1; st <= S_EN; end
                       end
            S_TD_TST:  if (req_ack) st <= S_TD_CTL;
            S_TD_CTL:  if (req_ack) st <= S_TD_MAP;
            S_TD_MAP:  if (req_ack) begin st <= S_IDLE; done_q <= 1'b1; end
            default:   st <= S_IDLE;
         endcase
      end
   end

   // request port decode
   always_comb begin
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = A_TST;
      req_wdata = V_ZERO;
      case (st)
         S_FORCE:   begin req_addr = A_CTRL; req_wdata = V_FORCE100; end
         S_MAPSTR:  begin req_addr = A_MAP;  req_wdata = V_ZERO;     end
         S_EN,
         S_MEAS_WR: begin req_addr = A_TST;  req_wdata = V_TEST;     end
         S_RD_AB,
         S_RD_M:    begin req_write = 1'b0;  req_addr = A_TST;       end
         S_XOVER:   begin req_addr = A_MAP;  req_wdata = V_XOVER;    end
         S_TD_TST:  begin req_addr = A_TST;  req_wdata = V_ZERO;     end
         S_TD_CTL:  begin req_addr = A_CTRL; req_wdata = V_ZERO;     end
         S_TD_MAP:  begin req_addr = A_MAP;  req_wdata = V_AUTO;     end
         default:   begin req_valid = 1'b0;  req_write = 1'b0;       end
      endcase
   end

   assign tmr_load   = (st == S_EN || st == S_MEAS_WR) && req_ack;
   assign trk_clear  = (st == S_RD_AB) && req_ack;
   assign trk_sample = (st == S_RD_M) && req_ack;

   always_comb begin
      rec_en   = 1'b0;
      rec_stat = ST_NONE;
      rec_data = trk_last;
      if (st == S_RD_AB && req_ack && !req_rdata[B_ABLE]) begin
         rec_en   = 1'b1;
         rec_stat = ST_NOABLE;
         rec_data = '0;
      end else if (st == S_EVAL && (trk_stable || trk_maxed)) begin
         rec_en   = 1'b1;
         rec_stat = trk_stable ? ST_STABLE : ST_TIMEOUT;
      end
   end

   // per-channel result registers
   for (genvar c = 0; c < NUM_CH; c++) begin : g_res
      logic [1:0]        stat_q;
      logic [RD_W-1:0]   data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat_q <= ST_NONE;
            data_q <= '0;
         end else if (st == S_IDLE && start) begin
            stat_q <= ST_NONE;
            data_q <= '0;
         end else if (rec_en && ch == CHW'(c)) begin
            stat_q <= rec_stat;
            data_q <= rec_data;
         end
      end
      assign ch_status[2*c +: 2]       = stat_q;
      assign ch_dist[DIST_W*c +: DIST_W] = data_q[DIST_W-1:0];
      assign ch_flags[2*c +: 2]        = data_q[RD_W-1 -: 2];
   end

   assign busy = (st != S_IDLE);
   assign done = done_q;

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ack) |=> (req_valid && $stable(req_write) && $stable(req_addr) && $stable(req_wdata)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ch_status[1:0] != 2'b00 && ch_status[3:2] != 2'b00));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid);

   // R4
   wait_to_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_load) |=> !req_valid);
endmodule

// File: tb/cabdiag_seq_bench.sv
module cabdiag_seq_bench;
   localparam int WAIT = 16;
   localparam int NEED = 3;
   localparam int MAXI = 100;

   typedef struct packed {
      logic        wr;
      logic [4:0]  addr;
      logic [15:0] data;
   } txn_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done;
   logic        req_valid, req_write;
   logic [4:0]  req_addr;
   logic [15:0] req_wdata;
   logic        req_ack = 1'b0;
   logic [15:0] req_rdata = '0;
   logic [3:0]  ch_status;
   logic [17:0] ch_dist;
   logic [3:0]  ch_flags;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ack_cyc = 0;
   logic last_was_test_wr = 1'b0;
   int ntx = 0;

   txn_t        exp_q[$];
   logic [15:0] rd_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cabdiag_seq #(.WAIT_CYCLES(WAIT), .MATCH_NEED(NEED), .MAX_ITER(MAXI)) u_cabdiag_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
      .ch_status(ch_status), .ch_dist(ch_dist), .ch_flags(ch_flags)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic push_w(input logic [4:0] a, input logic [15:0] d);
      exp_q.push_back('{wr: 1'b1, addr: a, data: d});
   endtask

   task automatic push_r(input logic [15:0] rv);
      exp_q.push_back('{wr: 1'b0, addr: 5'h1D, data: 16'h0});
      rd_q.push_back(rv);
   endtask

   // ability read value, then measurement readings
   task automatic push_channel(input logic able, input logic [15:0] rds[$]);
      push_w(5'h1D, 16'hC000);
      push_r(able ? 16'h4000 : 16'h3FFF);
      if (able) begin
         foreach (rds[i]) begin
            push_w(5'h1D, 16'hC000);
            push_r(rds[i]);
         end
      end
      push_w(5'h1C, 16'h0040);
   endtask

   task automatic push_setup();
      push_w(5'h00, 16'h2000);
      push_w(5'h1C, 16'h0000);
   endtask

   task automatic push_teardown();
      push_w(5'h1D, 16'h0000);
      push_w(5'h00, 16'h0000);
      push_w(5'h1C, 16'h0080);
   endtask

   // monitor / PHY model: pops expected transactions and answers them
   initial begin
      forever begin
         @(negedge clk);
         if (req_valid) begin
            txn_t e;
            if (exp_q.size() == 0) begin
               chk("R11 unexpected request", {req_write, req_addr, req_wdata}, 32'h0);
               e = '{wr: req_write, addr: req_addr, data: req_wdata};
            end else begin
               e = exp_q.pop_front();
               chk("R2 R9 request kind", {31'h0, req_write}, {31'h0, e.wr});
               chk("R2 R9 request addr", {27'h0, req_addr}, {27'h0, e.addr});
               if (e.wr) chk("R2 R9 request data", {16'h0, req_wdata}, {16'h0, e.data});
            end
            if (!req_write) begin
               if (last_was_test_wr) chk("R4 wait before read", cyc - ack_cyc, WAIT + 1);
               req_rdata = (rd_q.size() != 0) ? rd_q.pop_front() : 16'h0;
            end
            repeat (ntx % 3) begin
               @(negedge clk);
               // R3: fields hold while waiting
               chk("R3 hold addr", {27'h0, req_addr}, {27'h0, e.addr});
            end
            last_was_test_wr = req_write && req_addr == 5'h1D && req_wdata == 16'hC000;
            ack_cyc = cyc;
            ntx++;
            req_ack = 1'b1;
            @(negedge clk);
            req_ack = 1'b0;
         end
      end
   end

   task automatic wait_done(output int pulses);
      int n = 0;
      pulses = 0;
      while (n < 20000) begin
         @(negedge clk);
         n++;
         if (done) begin
            pulses++;
            chk("R10 busy low with done", {31'h0, busy}, 32'h0);
            break;
         end
      end
      @(negedge clk);
      if (done) pulses++;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic after_run(input int pulses);
      chk("R10 one done pulse", pulses, 1);
      chk("R9 all requests seen", exp_q.size(), 0);
      repeat (5) begin
         @(negedge clk);
         chk("R10 quiet after done", {31'h0, req_valid}, 32'h0);
      end
   endtask

   initial begin
      int p;
      logic [15:0] rds0[$];
      logic [15:0] rds1[$];
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", {31'h0, busy}, 32'h0);
      chk("R1 req_valid", {31'h0, req_valid}, 32'h0);
      chk("R1 done", {31'h0, done}, 32'h0);
      chk("R1 status", {28'h0, ch_status}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Run 1: ch0 stable after 3 equal readings (R6, R7); ch1 needs restart after mismatch
      rds0 = '{16'h8200 | 16'd37, 16'h8200 | 16'd37, 16'h8200 | 16'd37};
      rds1 = '{16'h0400 | 16'd121, 16'h0400 | 16'd121,
               16'h0400 | 16'd120, 16'h0400 | 16'd120, 16'h0400 | 16'd120};
      push_setup();
      push_channel(1'b1, rds0);
      push_channel(1'b1, rds1);
      push_teardown();
      pulse_start();
      wait_done(p);
      after_run(p);
      chk("R7 ch0 status stable", ch_status[1:0], 2'b01);
      chk("R6 ch0 distance", ch_dist[8:0], 9'd37);
      chk("R6 ch0 flags high", ch_flags[1:0], 2'b01);
      chk("R7 ch1 status after restart", ch_status[3:2], 2'b01);
      chk("R7 ch1 distance", ch_dist[17:9], 9'd120);
      chk("R6 ch1 flags low", ch_flags[3:2], 2'b10);

      // Run 2: ch0 ability fails (R5); ch1 flags alternate -> timeout (R8)
      rds0.delete();
      rds1.delete();
      for (int i = 1; i <= MAXI; i++)
         rds1.push_back(((i % 2) == 1) ? (16'h0400 | 16'd200) : (16'h0200 | 16'd200));
      push_setup();
      push_channel(1'b0, rds0);
      push_channel(1'b1, rds1);
      push_teardown();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R12 status cleared on start", {28'h0, ch_status}, 32'h0);
      wait_done(p);
      after_run(p);
      chk("R5 ch0 ability failed", ch_status[1:0], 2'b11);
      chk("R5 ch0 distance zero", ch_dist[8:0], 9'd0);
      chk("R5 ch0 flags zero", ch_flags[1:0], 2'b00);
      chk("R8 ch1 timed out", ch_status[3:2], 2'b10);
      chk("R8 ch1 last distance", ch_dist[17:9], 9'd200);
      chk("R8 ch1 last flags", ch_flags[3:2], 2'b01);

      // Run 3: both fail ability; extra start while busy is ignored (R11)
      push_setup();
      push_channel(1'b0, rds0);
      push_channel(1'b0, rds0);
      push_teardown();
      pulse_start();
      repeat (8) @(negedge clk);
      chk("R11 busy during run", {31'h0, busy}, 32'h1);
      pulse_start();
      wait_done(p);
      after_run(p);
      chk("R5 R11 ch0 status", ch_status[1:0], 2'b11);
      chk("R5 R11 ch1 status", ch_status[3:2], 2'b11);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule